// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt events for a small processor core and turns them into one request line. It keeps an 8-bit control register that holds a master enable, a group enable for peripheral sources, three enables for the core's own sources (timer overflow, external pin, port change) and their three event flags. It also keeps a parameterised number of 8-bit peripheral register pairs, one flag register and one enable register per pair. Every flag latches its event whatever the enables say, so software can poll it. A flag raises a request only through its own enable and the master enable. Peripheral flags must also pass the group enable.

When the core accepts the request, the block reports the fixed vector address 0x0004 and drops the master enable. A return strobe from the core sets the master enable again, so a flag that is still pending asks for service at once. A wake output shows any enabled pending flag whatever the master enable, so a sleeping core can resume. Software reaches all registers through a simple read/write port. Flags are cleared only by writing 0, and an event that arrives in the same cycle as that write wins.

Top module: `irqc_top`

## Requirements
- R1: Register address 0 holds the control register: bit7 master enable, bit6 peripheral group enable, bit5/bit4/bit3 enables of the timer, pin and port-change sources, bit2/bit1/bit0 their flags. All bits read 0 after reset.
- R2: A pulse on `core_evt[i]` sets control bit i, and a pulse on `per_evt[8k+j]` sets bit j of peripheral flag register k, whatever the enables hold.
- R3: `irq_req` is high when the master enable is set and either a core flag is set with its enable (flag bit i pairs with enable bit i+3), or the group enable is set and some peripheral flag is set with its matching enable bit.
- R4: `irq_ack` while `irq_req` is high drives `vec_valid` high in that same cycle with `vec_addr` = 0x0004. The master enable reads 0 and `irq_req` is low from the next cycle.
- R5: A `ret_strobe` pulse sets the master enable. If an enabled flag is still pending, `irq_req` is high in the next cycle.
- R6: A write to address 0 with bit7 = 0 makes `irq_req` low from the next cycle. The flags keep their value, and the request comes back once the master enable is written to 1.
- R7: `wake_req` is high when a core flag is set with its enable, or when a peripheral flag is set with its enable while the group enable is set. The master enable plays no part.
- R8: A flag clears only when a register write puts 0 in it. An event in the same cycle as that write leaves the flag set.
- R9: Peripheral pair k has its flags at address 1+2k and its enables at address 2+2k. Bits outside `PER_IMPL` read 0 and ignore writes and events. Addresses above the last register read 0.
- R10: For the master enable, acceptance takes priority over the return strobe, and the return strobe takes priority over a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(1+2*NPAIR) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| core_evt | input | 3 | Core source events: timer, pin, port change (bits 2..0) |
| per_evt | input | 8*NPAIR | Peripheral source events |
| irq_ack | input | 1 | Core accepts the request |
| ret_strobe | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| vec_valid | output | 1 | Vector load strobe to the program counter |
| vec_addr | output | VEC_W | Vector address (0x0004) |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench builds the block with two peripheral pairs and an implemented-bit mask of 0x7F3F. This makes two generated pairs with different holes: bit 7 is missing in both, and bits 6 and 7 are missing in pair 0. The three-bit address also reaches the unused codes 5 to 7. With this setup, masked writes, masked events and reads of empty addresses can all be seen at the ports. Directed sequences cover acceptance, return, write-side disable and the same-cycle priority cases. A long random phase then mixes writes, events, acknowledges and returns against the bench's behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_GIE  = 7;
  localparam int unsigned BIT_GRP  = 6;
  localparam int unsigned EN_HI    = 5;
  localparam int unsigned EN_LO    = 3;
  localparam int unsigned FL_HI    = 2;
  localparam int unsigned FL_LO    = 0;
  localparam int unsigned N_CORE   = FL_HI - FL_LO + 1;
  localparam logic [15:0] VEC_ADDR = 16'h0004;
endpackage

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N_CORE-1:0] evt,
  input  logic              take,
  input  logic              ret,
  output logic [REG_W-1:0]  ctrl_q,
  output logic              core_pend
);
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_ce;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d[BIT_GRP:EN_LO] = wdata[BIT_GRP:EN_LO];
    if (take)       ctrl_d[BIT_GIE] = 1'b0;
    else if (ret)   ctrl_d[BIT_GIE] = 1'b1;
    else if (wr_en) ctrl_d[BIT_GIE] = wdata[BIT_GIE];
    ctrl_d[FL_HI:FL_LO] = evt | (wr_en ? wdata[FL_HI:FL_LO] : ctrl_q[FL_HI:FL_LO]);
  end

  assign ctrl_ce = wr_en | take | ret | (|evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  assign core_pend = |(ctrl_q[FL_HI:FL_LO] & ctrl_q[EN_HI:EN_LO]);

  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ctrl_q[BIT_GIE]); // R4
  AST_RET_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> ctrl_q[BIT_GIE]); // R5
  AST_CORE_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((ctrl_q[FL_HI:FL_LO] & $past(evt)) == $past(evt))); // R2
  AST_CORE_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(|evt)) |=> $stable(ctrl_q[FL_HI:FL_LO])); // R8
endmodule

// File: rtl/irqc_per_pair.sv
module irqc_per_pair
  import irqc_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = '1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_flag,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] evt,
  output logic [REG_W-1:0] flag_q,
  output logic [REG_W-1:0] en_q,
  output logic             pend
);
  logic [REG_W-1:0] flag_d;
  logic [REG_W-1:0] en_d;
  logic             flag_ce;

  always_comb begin
    flag_d = (evt | (wr_flag ? wdata : flag_q)) & IMPL;
    en_d   = wdata & IMPL;
  end

  assign flag_ce = wr_flag | (|(evt & IMPL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ce) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  assign pend = |(flag_q & en_q);

  AST_PER_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & IMPL)) |=> ((flag_q & $past(evt & IMPL)) == $past(evt & IMPL))); // R2
  AST_PER_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flag && !(|(evt & IMPL))) |=> $stable(flag_q)); // R8
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned            NPAIR    = 2,
  parameter logic [NPAIR*8-1:0]     PER_IMPL = '1,
  parameter int unsigned            VEC_W    = 13,
  localparam int unsigned           NREG     = 1 + 2 * NPAIR,
  localparam int unsigned           AW       = $clog2(NREG)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [N_CORE-1:0]  core_evt,
  input  logic [NPAIR*8-1:0] per_evt,
  input  logic               irq_ack,
  input  logic               ret_strobe,
  output logic               irq_req,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               wake_req
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [REG_W-1:0] ctrl_q;
  logic             core_pend;
  logic             wr_ctrl;
  logic             take;
  logic             grp_pend;
  logic             src_pend;
  logic [NPAIR-1:0] pair_pend;
  logic [REG_W-1:0] pf_arr [NPAIR];
  logic [REG_W-1:0] pe_arr [NPAIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign wr_ctrl = reg_we && (reg_addr == '0);

  irqc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_ctrl),
    .wdata     (reg_wdata),
    .evt       (core_evt),
    .take      (take),
    .ret       (ret_strobe),
    .ctrl_q    (ctrl_q),
    .core_pend (core_pend)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic wr_f;
    logic wr_e;
    assign wr_f = reg_we && (reg_addr == AW'(1 + 2 * k));
    assign wr_e = reg_we && (reg_addr == AW'(2 + 2 * k));
    irqc_per_pair #(.IMPL(PER_IMPL[k*8 +: 8])) u_pair (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_flag (wr_f),
      .wr_en   (wr_e),
      .wdata   (reg_wdata),
      .evt     (per_evt[k*8 +: 8]),
      .flag_q  (pf_arr[k]),
      .en_q    (pe_arr[k]),
      .pend    (pair_pend[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = ctrl_q;
    for (int k = 0; k < NPAIR; k++) begin
      if (reg_addr == AW'(1 + 2 * k)) reg_rdata = pf_arr[k];
      if (reg_addr == AW'(2 + 2 * k)) reg_rdata = pe_arr[k];
    end
  end

  assign grp_pend  = ctrl_q[BIT_GRP] & (|pair_pend);
  assign src_pend  = core_pend | grp_pend;
  assign wake_req  = src_pend;
  assign irq_req   = ctrl_q[BIT_GIE] & src_pend;
  assign take      = irq_ack & irq_req;
  assign vec_valid = take;
  assign vec_addr  = VEC_ADDR[VEC_W-1:0];

  AST_NO_REQ_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_core_n)
    take |=> !irq_req); // R4
  AST_WRITE_MASKS_REQ: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_ctrl && !reg_wdata[BIT_GIE] && !ret_strobe) |=> !irq_req); // R6
  AST_RET_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ret_strobe && !take && !reg_we && !(|core_evt) && src_pend) |=> irq_req); // R5
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NP         = 2;
  localparam logic [15:0] IMPL       = 16'h7F3F;
  localparam int          AW         = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic [2:0]    core_evt;
  logic [15:0]   per_evt;
  logic          irq_ack;
  logic          ret_strobe;
  logic          irq_req;
  logic          vec_valid;
  logic [12:0]   vec_addr;
  logic          wake_req;

  irqc_top #(.NPAIR(NP), .PER_IMPL(IMPL), .VEC_W(13)) i_irqc_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_evt(core_evt),
    .per_evt(per_evt), .irq_ack(irq_ack), .ret_strobe(ret_strobe),
    .irq_req(irq_req), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .wake_req(wake_req)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [7:0] m_ctrl;
  logic [7:0] m_pf [NP];
  logic [7:0] m_pe [NP];

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input int a);
    if (a == 0) return m_ctrl;
    for (int k = 0; k < NP; k++) begin
      if (a == 1 + 2 * k) return m_pf[k];
      if (a == 2 + 2 * k) return m_pe[k];
    end
    return 8'h00;
  endfunction

  task automatic idle();
    reg_we = 0; core_evt = 0; per_evt = 0; irq_ack = 0; ret_strobe = 0;
  endtask

  // Check outputs against the model, advance the model, move to the next negedge.
  task automatic cyc();
    bit cp, pp, exp_req, exp_wake, tk, gie_n;
    #2;
    cp = 0; pp = 0;
    for (int i = 0; i < 3; i++) if (m_ctrl[i] && m_ctrl[i+3]) cp = 1;
    for (int k = 0; k < NP; k++)
      for (int j = 0; j < 8; j++) if (m_pf[k][j] && m_pe[k][j]) pp = 1;
    exp_wake = cp || (m_ctrl[6] && pp);
    exp_req  = m_ctrl[7] && exp_wake;
    tk = irq_ack && exp_req;
    chk("R3 irq_req", {15'd0, irq_req}, {15'd0, exp_req});
    chk("R7 wake_req", {15'd0, wake_req}, {15'd0, exp_wake});
    chk("R4 vec_valid", {15'd0, vec_valid}, {15'd0, tk});
    if (tk) chk("R4 vec_addr", {3'd0, vec_addr}, 16'h0004);
    chk("R9 reg_rdata", {8'd0, reg_rdata}, {8'd0, m_read(int'(reg_addr))});
    gie_n = m_ctrl[7];
    if (tk) gie_n = 0;
    else if (ret_strobe) gie_n = 1;
    else if (reg_we && reg_addr == 0) gie_n = reg_wdata[7];
    if (reg_we && reg_addr == 0) m_ctrl = {gie_n, reg_wdata[6:3], reg_wdata[2:0] | core_evt};
    else m_ctrl = {gie_n, m_ctrl[6:3], m_ctrl[2:0] | core_evt};
    for (int k = 0; k < NP; k++) begin
      logic [7:0] msk;
      msk = IMPL[k*8 +: 8];
      if (reg_we && int'(reg_addr) == 1 + 2 * k) m_pf[k] = (reg_wdata | per_evt[k*8 +: 8]) & msk;
      else m_pf[k] = (m_pf[k] | per_evt[k*8 +: 8]) & msk;
      if (reg_we && int'(reg_addr) == 2 + 2 * k) m_pe[k] = reg_wdata & msk;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    cyc();
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    reg_addr = AW'(a);
    #1;
    chk(tag, {8'd0, reg_rdata}, {8'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); reg_addr = 0; reg_wdata = 0;
    m_ctrl = 0;
    for (int k = 0; k < NP; k++) begin m_pf[k] = 0; m_pe[k] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    rd(0, 8'h00, "R1 reset control");
    rd(1, 8'h00, "R9 reset pair0 flags");
    rd(4, 8'h00, "R9 reset pair1 enables");

    core_evt = 3'b100; cyc();
    rd(0, 8'h04, "R2 timer flag with enables off");
    chk("R3 no request while disabled", {15'd0, irq_req}, 16'd0);
    per_evt = 16'h0001; cyc();
    rd(1, 8'h01, "R2 peripheral flag with enables off");

    wr(0, 8'hA4);
    chk("R3 core request", {15'd0, irq_req}, 16'd1);
    irq_ack = 1; #1;
    chk("R4 vec_valid on accept", {15'd0, vec_valid}, 16'd1);
    chk("R4 vec_addr on accept", {3'd0, vec_addr}, 16'h0004);
    cyc();
    chk("R4 request dropped after accept", {15'd0, irq_req}, 16'd0);
    rd(0, 8'h24, "R4 master enable cleared");

    ret_strobe = 1; cyc();
    chk("R5 request after return", {15'd0, irq_req}, 16'd1);
    rd(0, 8'hA4, "R5 master enable set");

    wr(0, 8'h24);
    chk("R6 request masked by write", {15'd0, irq_req}, 16'd0);
    rd(0, 8'h24, "R6 flag still pending");
    wr(0, 8'hA4);
    chk("R6 request back", {15'd0, irq_req}, 16'd1);

    reg_we = 1; reg_addr = 0; reg_wdata = 8'hA0; core_evt = 3'b100; cyc();
    rd(0, 8'hA4, "R8 event beats clear");
    wr(0, 8'hA0);
    rd(0, 8'hA0, "R8 write of 0 clears");
    chk("R8 no request after clear", {15'd0, irq_req}, 16'd0);

    wr(2, 8'h01);
    chk("R3 no request without group enable", {15'd0, irq_req}, 16'd0);
    chk("R7 no wake without group enable", {15'd0, wake_req}, 16'd0);
    wr(0, 8'hE0);
    chk("R3 peripheral request", {15'd0, irq_req}, 16'd1);
    wr(0, 8'h60);
    chk("R7 wake with master off", {15'd0, wake_req}, 16'd1);
    chk("R6 request off", {15'd0, irq_req}, 16'd0);

    wr(1, 8'hFF);
    rd(1, 8'h3F, "R9 pair0 unimplemented bits");
    wr(3, 8'hFF);
    rd(3, 8'h7F, "R9 pair1 unimplemented bits");
    wr(1, 8'h00); wr(3, 8'h00);
    per_evt = 16'h8080; cyc();
    rd(1, 8'h00, "R9 pair0 masked event");
    rd(3, 8'h00, "R9 pair1 masked event");
    rd(7, 8'h00, "R9 address beyond last");

    per_evt = 16'h0001; cyc();
    wr(0, 8'hE0);
    irq_ack = 1; ret_strobe = 1; reg_we = 1; reg_addr = 0; reg_wdata = 8'hE0; cyc();
    rd(0, 8'h60, "R10 accept over return and write");
    ret_strobe = 1; reg_we = 1; reg_addr = 0; reg_wdata = 8'h60; cyc();
    rd(0, 8'hE0, "R10 return over write");

    for (int n = 0; n < 3000; n++) begin
      reg_we     = ($urandom % 4) == 0;
      reg_addr   = AW'($urandom % 8);
      reg_wdata  = 8'($urandom);
      core_evt   = (($urandom % 6) == 0) ? 3'($urandom) : 3'd0;
      per_evt    = (($urandom % 5) == 0) ? 16'($urandom) : 16'd0;
      irq_ack    = ($urandom % 2) == 0;
      ret_strobe = ($urandom % 8) == 0;
      cyc();
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule